// File: doc/BRIEF.md
# DQS Gate Calibration Sequencer

This block runs a single read-gate (DQS squelch) calibration pass on a 16-bit memory PHY built from two byte lanes. It also keeps refresh timing intact while the pass runs. One start pulse begins the pass. The sequencer saves the controller's refresh-interval value and writes zero to it, which stops auto-refresh. It then drives the PHY calibration control to "run" and waits for both byte lanes to report done. After that it returns the control to "off", asks a command issuer for a burst of make-up auto-refresh commands to every rank, writes the saved interval back, and pulses done.

The PHY side is a 2-bit control output and a 2-bit per-lane status input. Refresh commands use a request/acknowledge pair. A settle counter delays the first status sample after calibration is armed. A timeout counter bounds the wait. If the timeout expires, the block raises an error flag and still completes the refresh burst and the restore.

Top module: `dqs_gate_cal_seq`

## Requirements
- R1: On an accepted start the block captures `trefi_rd`, then writes zero to the interval (`trefi_wr_en` high with `trefi_wr_data` zero) before `cal_ctrl` first becomes 2'b01. The interval stays zero for the whole time `cal_ctrl` is 2'b01.
- R2: `cal_ctrl` only ever carries 2'b01 (normal mode, calibration running) or 2'b00 (normal mode, no calibration). It is 2'b00 out of reset and whenever the block is idle.
- R3: After `cal_ctrl` becomes 2'b01, the status is not sampled for SETTLE_CYC cycles. If both lanes are already done from the start, `cal_ctrl` stays 2'b01 for exactly SETTLE_CYC+1 cycles.
- R4: Calibration succeeds only when `cal_status` equals 2'b11 (bit 0 is the low-byte lane, bit 1 is the high-byte lane). If D is the cycle index at which the later lane finishes, then `cal_ctrl` stays 2'b01 for max(SETTLE_CYC, D)+1 cycles. One lane done alone never ends the wait.
- R5: Once `cal_ctrl` has returned to 2'b00, the block issues exactly three auto-refresh requests. `ref_req` is never high while `cal_ctrl` is 2'b01. A request counts as issued when `ref_req` and `ref_ack` are both high in one cycle.
- R6: `ref_rank` is 2'b11 (both chip selects) whenever `ref_req` is high.
- R7: The saved interval is written back only after the third refresh acknowledge. After the pass, the interval equals its value before the pass.
- R8: A start pulse that arrives while `busy` is high is ignored: no second pass, no extra refreshes, and no loss of the saved interval.
- R9: `done` is high for exactly one cycle per pass. `busy` is high from the cycle after an accepted start until that done cycle, and low afterwards.
- R10: If the status is not 2'b11 within TIMEOUT_CYC cycles of the first sample, `err` rises, `cal_ctrl` returns to 2'b00 after SETTLE_CYC+TIMEOUT_CYC cycles at 2'b01, and the refresh burst and the restore still happen. `err` stays high until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run a calibration pass |
| trefi_rd | input | TREFI_W | Current refresh-interval value |
| trefi_wr_en | output | 1 | Write strobe for the refresh-interval value |
| trefi_wr_data | output | TREFI_W | Value to write to the refresh interval |
| cal_ctrl | output | 2 | PHY calibration control (01 run, 00 off) |
| cal_status | input | 2 | Per-lane done flags (bit 0 low byte, bit 1 high byte) |
| ref_req | output | 1 | Auto-refresh command request |
| ref_rank | output | 2 | Rank mask for the refresh command |
| ref_ack | input | 1 | Refresh command accepted |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pass-complete pulse |
| err | output | 1 | Last pass timed out waiting for both lanes |

## Verification
The bench builds the block with SETTLE_CYC=4, TIMEOUT_CYC=20 and a 16-bit interval. With these values, lanes that finish before the settle window ends, inside the poll window, and on its last cycle (index 23) are all reachable in a few dozen cycles. The bench also covers a single lane that never finishes and two lanes that never finish, which take the timeout path. The refresh responder acknowledges after zero to three cycles of delay, and a start is injected in the middle of a pass. This exercises the three-command count, the ordering of the restore, and how busy starts are handled.

// File: rtl/dqs_cal_pkg.sv
// Package: shared encodings and state type of the DQS gate calibration sequencer.
// Assumes: two byte lanes, a 2-bit calibration control and a 2-bit rank mask.
package dqs_cal_pkg;

    localparam logic [1:0] CAL_OFF  = 2'b00;  // normal mode, calibration idle
    localparam logic [1:0] CAL_RUN  = 2'b01;  // normal mode, calibration started
    localparam logic [1:0] LANES_OK = 2'b11;  // both byte lanes report done
    localparam logic [1:0] RANK_ALL = 2'b11;  // both chip selects

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ZERO,
        SQ_ARM,
        SQ_POLL,
        SQ_STOP,
        SQ_REFR,
        SQ_RESTORE,
        SQ_FINISH
    } seq_state_t;

endpackage

// File: rtl/dqs_cal_timer.sv
// Module: up-counting window timer.
// Counts cycles while run is high; hit flags the last cycle of a LIMIT-cycle window.
// Assumes: LIMIT >= 1; clr has priority over run and returns the count to zero.
module dqs_cal_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic hit
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Flag the final cycle of the window.
    assign hit = run && (cnt_q == LAST);

    // Advance the window count, holding at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && !hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);  // R3

endmodule

// File: rtl/dqs_cal_ref_burst.sv
// Module: make-up refresh burst issuer.
// On launch, holds a refresh request until BURST acknowledges have been seen,
// then drops the request and pulses burst_done for one cycle.
// Assumes: an acknowledge is a one-cycle pulse seen while the request is high.
module dqs_cal_ref_burst #(
    parameter int BURST = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic ref_ack,
    output logic ref_req,
    output logic burst_done
);
    localparam int CW = (BURST < 2) ? 1 : $clog2(BURST + 1);
    localparam logic [CW-1:0] LAST = CW'(BURST - 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    assign ref_req    = active_q;
    assign burst_done = done_q;

    // Track accepted commands and end the burst on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch && !active_q) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
            end else if (active_q && ref_ack) begin
                if (cnt_q == LAST) begin
                    active_q <= 1'b0;
                    cnt_q    <= '0;
                    done_q   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_BURST_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q <= LAST));  // R5
    AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_req) |-> burst_done);  // R5

endmodule

// File: rtl/dqs_gate_cal_seq.sv
// Module: DQS gate calibration sequencer (top).
// Runs one squelch calibration pass: save and zero the refresh interval, run
// calibration until both lanes are done (or time out), issue make-up refreshes
// to all ranks, restore the interval and pulse done.
// Assumes: cal_status clears when cal_ctrl returns to off; ref_ack is a pulse.
module dqs_gate_cal_seq
    import dqs_cal_pkg::*;
#(
    parameter int TREFI_W     = 16,
    parameter int SETTLE_CYC  = 400,
    parameter int TIMEOUT_CYC = 20000,
    parameter int REF_BURST   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [TREFI_W-1:0] trefi_rd,
    output logic               trefi_wr_en,
    output logic [TREFI_W-1:0] trefi_wr_data,
    output logic [1:0]         cal_ctrl,
    input  logic [1:0]         cal_status,
    output logic               ref_req,
    output logic [1:0]         ref_rank,
    input  logic               ref_ack,
    output logic               busy,
    output logic               done,
    output logic               err
);
    seq_state_t         state_q, state_d;
    logic [TREFI_W-1:0] saved_q;
    logic               err_q;
    logic               settle_hit, tmo_hit;
    logic               burst_launch, burst_done;
    logic               lanes_ok;

    assign lanes_ok = (cal_status == LANES_OK);

    // Settle window: runs only while arming.
    dqs_cal_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != SQ_ARM),
        .run   (state_q == SQ_ARM),
        .hit   (settle_hit)
    );

    // Timeout window: runs only while polling the lane flags.
    dqs_cal_timer #(.LIMIT(TIMEOUT_CYC)) u_timeout (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != SQ_POLL),
        .run   (state_q == SQ_POLL),
        .hit   (tmo_hit)
    );

    // Make-up refresh burst.
    dqs_cal_ref_burst #(.BURST(REF_BURST)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (burst_launch),
        .ref_ack    (ref_ack),
        .ref_req    (ref_req),
        .burst_done (burst_done)
    );

    // Next-state selection for the pass.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:    if (start) state_d = SQ_ZERO;
            SQ_ZERO:    state_d = SQ_ARM;
            SQ_ARM:     if (settle_hit) state_d = SQ_POLL;
            SQ_POLL:    if (lanes_ok || tmo_hit) state_d = SQ_STOP;
            SQ_STOP:    state_d = SQ_REFR;
            SQ_REFR:    if (burst_done) state_d = SQ_RESTORE;
            SQ_RESTORE: state_d = SQ_FINISH;
            SQ_FINISH:  state_d = SQ_IDLE;
            default:    state_d = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Capture the interval on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                             saved_q <= '0;
        else if (state_q == SQ_IDLE && start)   saved_q <= trefi_rd;
    end

    // Error flag: cleared by an accepted start, set by a timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       err_q <= 1'b0;
        else if (state_q == SQ_IDLE && start)             err_q <= 1'b0;
        else if (state_q == SQ_POLL && !lanes_ok && tmo_hit) err_q <= 1'b1;
    end

    // Output decode from the state.
    assign burst_launch  = (state_q == SQ_STOP);
    assign trefi_wr_en   = (state_q == SQ_ZERO) || (state_q == SQ_RESTORE);
    assign trefi_wr_data = (state_q == SQ_RESTORE) ? saved_q : '0;
    assign cal_ctrl      = (state_q == SQ_ARM || state_q == SQ_POLL) ? CAL_RUN : CAL_OFF;
    assign ref_rank      = RANK_ALL;
    assign busy          = (state_q != SQ_IDLE);
    assign done          = (state_q == SQ_FINISH);
    assign err           = err_q;

    AST_CTRL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_ctrl == CAL_RUN) || (cal_ctrl == CAL_OFF));  // R2
    AST_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_ctrl[0]) |-> ($past(trefi_wr_en) && ($past(trefi_wr_data) == '0)));  // R1
    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_ARM && !settle_hit) |=> (cal_ctrl == CAL_RUN));  // R3
    AST_REF_NO_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (cal_ctrl == CAL_OFF));  // R5
    AST_RANK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (ref_rank == RANK_ALL));  // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(cal_ctrl) == CAL_RUN && $past(cal_status) != LANES_OK));  // R10

endmodule

// File: tb/dqs_gate_cal_seq_tb.sv
// Bench: vector table of calibration passes, then directed reset and busy-start tests.
module dqs_gate_cal_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TW  = 16;
    localparam int SET = 4;
    localparam int TMO = 20;
    localparam int NV  = 6;
    localparam int NEVER = 255;

    localparam int V_TREFI [NV] = '{'h018c, 'h0200, 'h0abc, 'h1234, 'h0777, 'h0042};
    localparam int V_D0    [NV] = '{2, 10, 7, 5, NEVER, 23};
    localparam int V_D1    [NV] = '{3, 6, 12, NEVER, NEVER, 23};
    localparam int V_ACKD  [NV] = '{0, 2, 1, 0, 3, 1};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [TW-1:0] trefi_rd, trefi_wr_data;
    logic trefi_wr_en, ref_req, ref_ack, busy, done, err;
    logic [1:0] cal_ctrl, cal_status, ref_rank;

    int checks = 0, fails = 0;

    // Environment models
    logic [TW-1:0] trefi_reg;
    logic [TW-1:0] preset_val = '0;
    logic preset_go = 1'b0;
    int d0 = 0, d1 = 0, ackd = 0;
    int lane_cnt, ack_wait;

    // Monitor results
    int ctrl_len, acks, acks_at_restore, done_cnt;
    bit zero_viol, bad_ctrl, bad_ref, bad_rank, dbl_done, prev_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    dqs_gate_cal_seq #(.TREFI_W(TW), .SETTLE_CYC(SET), .TIMEOUT_CYC(TMO), .REF_BURST(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .trefi_rd(trefi_rd),
        .trefi_wr_en(trefi_wr_en), .trefi_wr_data(trefi_wr_data),
        .cal_ctrl(cal_ctrl), .cal_status(cal_status),
        .ref_req(ref_req), .ref_rank(ref_rank), .ref_ack(ref_ack),
        .busy(busy), .done(done), .err(err)
    );

    assign trefi_rd = trefi_reg;
    assign cal_status = {cal_ctrl[0] && (lane_cnt >= d1), cal_ctrl[0] && (lane_cnt >= d0)};

    // Refresh-interval register, PHY lane stub and refresh responder
    always @(posedge clk) begin
        if (preset_go) trefi_reg <= preset_val;
        else if (trefi_wr_en) trefi_reg <= trefi_wr_data;
        lane_cnt <= (cal_ctrl == 2'b01) ? lane_cnt + 1 : 0;
        if (!rst_n) begin
            ref_ack <= 1'b0; ack_wait <= 0;
        end else if (ref_req && !ref_ack && ack_wait >= ackd) begin
            ref_ack <= 1'b1; ack_wait <= 0;
        end else begin
            ref_ack <= 1'b0;
            if (ref_req && !ref_ack) ack_wait <= ack_wait + 1;
        end
    end

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cal_ctrl == 2'b01) begin
                ctrl_len++;
                if (trefi_reg != '0) zero_viol = 1;
            end
            if (cal_ctrl != 2'b01 && cal_ctrl != 2'b00) bad_ctrl = 1;
            if (ref_req && cal_ctrl != 2'b00) bad_ref = 1;
            if (ref_req && ref_rank != 2'b11) bad_rank = 1;
            if (ref_req && ref_ack) acks++;
            if (trefi_wr_en && trefi_wr_data != '0) acks_at_restore = acks;
            if (done) begin
                done_cnt++;
                if (prev_done) dbl_done = 1;
            end
            prev_done = done;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        ctrl_len = 0; acks = 0; acks_at_restore = -1; done_cnt = 0;
        zero_viol = 0; bad_ctrl = 0; bad_ref = 0; bad_rank = 0; dbl_done = 0;
    endtask

    task automatic preset(input int val);
        @(negedge clk); preset_val = TW'(val); preset_go = 1'b1;
        @(negedge clk); preset_go = 1'b0;
    endtask

    // Run one pass; optionally pulse start again mid-pass
    task automatic run_pass(input int val, input int a0, input int a1, input int ad,
                            input bit mid_start);
        int exp_len, dmax;
        bit exp_err;
        bit seen_done = 0;
        d0 = a0; d1 = a1; ackd = ad;
        preset(val);
        clear_mon();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
        for (int i = 0; i < 400 && !seen_done; i++) begin
            @(negedge clk);
            if (mid_start && i == 6) start = 1'b1;
            else start = 1'b0;
            if (done) seen_done = 1;
        end
        start = 1'b0;
        check(seen_done, "R9", "done seen", int'(seen_done), 1);
        repeat (8) @(negedge clk);
        dmax = (a0 > a1) ? a0 : a1;
        if (dmax <= SET + TMO - 1) begin
            exp_err = 0; exp_len = ((SET > dmax) ? SET : dmax) + 1;
        end else begin
            exp_err = 1; exp_len = SET + TMO;
        end
        check(ctrl_len == exp_len, (exp_err ? "R10" : (dmax <= SET ? "R3" : "R4")),
              "cal run cycles", ctrl_len, exp_len);
        check(err == exp_err, "R10", "err flag", int'(err), int'(exp_err));
        check(!zero_viol, "R1", "interval zero during cal", int'(zero_viol), 0);
        check(!bad_ctrl, "R2", "ctrl encoding", int'(bad_ctrl), 0);
        check(acks == 3, "R5", "refresh count", acks, 3);
        check(!bad_ref, "R5", "refresh while cal", int'(bad_ref), 0);
        check(!bad_rank, "R6", "rank mask", int'(bad_rank), 0);
        check(acks_at_restore == 3, "R7", "acks before restore", acks_at_restore, 3);
        check(int'(trefi_reg) == val, "R7", "restored interval", int'(trefi_reg), val);
        check(done_cnt == 1 && !dbl_done, "R9", "done pulses", done_cnt, 1);
        check(!busy, "R9", "idle after done", int'(busy), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        d0 = NEVER; d1 = NEVER;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R2, R9)
        check(cal_ctrl == 2'b00, "R2", "reset ctrl", int'(cal_ctrl), 0);
        check(!busy && !done && !err, "R9", "reset busy/done/err",
              int'({busy, done, err}), 0);
        check(!ref_req && !trefi_wr_en, "R5", "reset req/write",
              int'({ref_req, trefi_wr_en}), 0);

        // Table of passes (R1-R7, R9, R10)
        for (int v = 0; v < NV; v++)
            run_pass(V_TREFI[v], V_D0[v], V_D1[v], V_ACKD[v], 1'b0);

        // R8: start while busy is ignored
        run_pass('h0321, 9, 8, 2, 1'b1);
        check(done_cnt == 1, "R8", "single pass on busy start", done_cnt, 1);
        check(acks == 3, "R8", "no extra refreshes", acks, 3);
        check(int'(trefi_reg) == 'h0321, "R8", "interval kept", int'(trefi_reg), 'h0321);

        // R10: err cleared by next accepted start
        run_pass('h00ff, 1, NEVER, 0, 1'b0);
        run_pass('h0fff, 5, 5, 0, 1'b0);
        check(!err, "R10", "err cleared by new pass", int'(err), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule